// File: doc/BRIEF.md
# Dual-Plane Flash Command Sequencer

This block turns one host request into the complete bus conversation that runs a single operation on two planes of the same flash die at once. The host names the operation, gives one address for each plane and pulses a start strobe. The sequencer then drives the command-latch, address-latch, write-enable and read-enable strobes and the 8-bit data bus. It loads both plane addresses under one shared command, triggers the die once, waits out the shared ready/busy period and then moves each plane's page in turn.

Three paired operations are supported: page read, page program and block erase. Both planes always perform the same operation, so a request whose two operation codes differ is refused. A read confirms once after both addresses and fetches the second plane's page through a reselect sequence. A program closes the first plane with a confirm that does not start programming and the second with one that starts both planes. An erase loads both block addresses and runs both erases under one busy period. After a program or erase the sequencer reads the status byte and reports its fail bit. A programmable timeout guards every ready/busy wait.

Top module: `mpn_seq`

## Requirements
- R1: When idle, a start with `op_a` different from `op_b`, or with code 3, is refused: `err_mix` pulses for one cycle one clock after the start, `busy` stays low and no strobe occurs on the flash bus. Operation codes are 0 read, 1 program, 2 erase.
- R2: A read issues, in order, command 00h, five address cycles for plane A, command 00h, five address cycles for plane B and then a single 30h confirm. Address cycles send `addr[7:0]`, `addr[15:8]`, `addr[23:16]`, `addr[31:24]`, `addr[39:32]` in that order (two column, three row). Command and address latch are never high together.
- R3: After a 30h, 10h or D0h confirm, no command, address or data strobe is issued while ready/busy is low; the sequencer waits `WB_CYC` cycles before it trusts the ready/busy line and then waits for it to be high.
- R4: After the read busy period, plane A's page is returned on `rd_data` with `rd_plane`=0, then 06h, plane B's five address cycles and E0h are issued, and plane B's page follows with `rd_plane`=1.
- R5: A program issues 80h, plane A's five address cycles, plane A's page taken from `wr_data`, 11h, a ready wait, 80h, plane B's address cycles, plane B's page and 10h. `wr_req` pulses once per byte taken, only during a program.
- R6: An erase issues 60h, the three row cycles of plane A, 60h, the three row cycles of plane B and a single D0h, followed by one busy period.
- R7: After a program or erase completes, the sequencer issues 70h, reads one status byte and presents its bit 0 on `status_fail` from `done` until the next accepted start; a read leaves `status_fail` low.
- R8: Each plane's data phase moves exactly `PAGE_BYTES` bytes (default 4314), no more and no fewer.
- R9: If a ready/busy wait lasts `busy_limit` cycles, the operation is abandoned: `done` pulses with `err_timeout` high, `busy` drops and the bus stays idle.
- R10: After reset the bus is idle (both enables high, latches low, bus not driven) and `busy` is low; `busy` is high from the accepted start to completion and `done` is a one-cycle pulse with `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken when idle |
| op_a | input | 2 | Operation for plane A (0 read, 1 program, 2 erase) |
| op_b | input | 2 | Operation for plane B, must equal op_a |
| addr_a | input | 40 | Column and row address for plane A |
| addr_b | input | 40 | Column and row address for plane B |
| busy_limit | input | TO_W | Ready/busy wait limit in cycles |
| wr_data | input | 8 | Next program byte |
| wr_req | output | 1 | Pulse: one program byte consumed |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Pulse: rd_data valid |
| rd_plane | output | 1 | Plane of rd_data |
| busy | output | 1 | Request in progress |
| done | output | 1 | Pulse: request finished |
| err_mix | output | 1 | Pulse: request refused |
| err_timeout | output | 1 | Last request ended by timeout |
| status_fail | output | 1 | Fail bit of the last status read |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write enable, active low |
| fl_re_n | output | 1 | Read enable, active low |
| fl_dq_out | output | 8 | Bus value driven to flash |
| fl_dq_oe | output | 1 | Bus output enable |
| fl_dq_in | input | 8 | Bus value from flash |
| fl_rb_n | input | 1 | Ready/busy, low while busy |

## Verification
Every cycle the assertions check that no write strobe falls inside a busy period, that the two latch enables are exclusive, that a mixed request is refused without starting, that program byte requests appear only in a program, that a timeout only ends a wait, that the byte counter wraps exactly at the page length and that completion never coincides with busy. The order and values of commands and address cycles, the byte content and plane tag of both pages, the status fail bit and the length of the wait after each confirm can only be shown by the bench's scenarios against a flash model, which compare every bus cycle with a queue of expected items.

// File: rtl/mpn_pkg.sv
package mpn_pkg;
  localparam int IW          = 4;
  localparam int ADDR_CYCLES = 5;
  localparam int ROW_START   = 2;

  typedef enum logic [1:0] {OP_READ = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2, OP_BAD = 2'd3} op_e;
  typedef enum logic [2:0] {K_CMD, K_ADDR, K_WDATA, K_RDATA, K_WAIT, K_STAT, K_END} kind_e;

  typedef struct packed {
    kind_e      kind;
    logic       plane;
    logic [7:0] val;
  } step_t;

  localparam logic [7:0] C_RD_OPEN  = 8'h00;
  localparam logic [7:0] C_RD_GO    = 8'h30;
  localparam logic [7:0] C_RD_SEL   = 8'h06;
  localparam logic [7:0] C_RD_SELGO = 8'hE0;
  localparam logic [7:0] C_PG_OPEN  = 8'h80;
  localparam logic [7:0] C_PG_HOLD  = 8'h11;
  localparam logic [7:0] C_PG_GO    = 8'h10;
  localparam logic [7:0] C_ER_OPEN  = 8'h60;
  localparam logic [7:0] C_ER_GO    = 8'hD0;
  localparam logic [7:0] C_STATUS   = 8'h70;
endpackage

// File: rtl/mpn_step_rom.sv
module mpn_step_rom
  import mpn_pkg::*;
(
  input  op_e             op,
  input  logic [IW-1:0]   idx,
  output step_t           step
);
  function automatic step_t mk(kind_e k, logic p, logic [7:0] v);
    step_t s;
    s.kind  = k;
    s.plane = p;
    s.val   = v;
    return s;
  endfunction

  always_comb begin
    step = mk(K_END, 1'b0, 8'h00);
    unique case (op)
      OP_READ: begin
        unique case (idx)
          4'd0:    step = mk(K_CMD,   1'b0, C_RD_OPEN);
          4'd1:    step = mk(K_ADDR,  1'b0, 8'h00);
          4'd2:    step = mk(K_CMD,   1'b0, C_RD_OPEN);
          4'd3:    step = mk(K_ADDR,  1'b1, 8'h00);
          4'd4:    step = mk(K_CMD,   1'b0, C_RD_GO);
          4'd5:    step = mk(K_WAIT,  1'b0, 8'h00);
          4'd6:    step = mk(K_RDATA, 1'b0, 8'h00);
          4'd7:    step = mk(K_CMD,   1'b0, C_RD_SEL);
          4'd8:    step = mk(K_ADDR,  1'b1, 8'h00);
          4'd9:    step = mk(K_CMD,   1'b0, C_RD_SELGO);
          4'd10:   step = mk(K_RDATA, 1'b1, 8'h00);
          default: step = mk(K_END,   1'b0, 8'h00);
        endcase
      end
      OP_PROG: begin
        unique case (idx)
          4'd0:    step = mk(K_CMD,   1'b0, C_PG_OPEN);
          4'd1:    step = mk(K_ADDR,  1'b0, 8'h00);
          4'd2:    step = mk(K_WDATA, 1'b0, 8'h00);
          4'd3:    step = mk(K_CMD,   1'b0, C_PG_HOLD);
          4'd4:    step = mk(K_WAIT,  1'b0, 8'h00);
          4'd5:    step = mk(K_CMD,   1'b0, C_PG_OPEN);
          4'd6:    step = mk(K_ADDR,  1'b1, 8'h00);
          4'd7:    step = mk(K_WDATA, 1'b1, 8'h00);
          4'd8:    step = mk(K_CMD,   1'b0, C_PG_GO);
          4'd9:    step = mk(K_WAIT,  1'b0, 8'h00);
          4'd10:   step = mk(K_CMD,   1'b0, C_STATUS);
          4'd11:   step = mk(K_STAT,  1'b0, 8'h00);
          default: step = mk(K_END,   1'b0, 8'h00);
        endcase
      end
      OP_ERASE: begin
        unique case (idx)
          4'd0:    step = mk(K_CMD,   1'b0, C_ER_OPEN);
          4'd1:    step = mk(K_ADDR,  1'b0, 8'h00);
          4'd2:    step = mk(K_CMD,   1'b0, C_ER_OPEN);
          4'd3:    step = mk(K_ADDR,  1'b1, 8'h00);
          4'd4:    step = mk(K_CMD,   1'b0, C_ER_GO);
          4'd5:    step = mk(K_WAIT,  1'b0, 8'h00);
          4'd6:    step = mk(K_CMD,   1'b0, C_STATUS);
          4'd7:    step = mk(K_STAT,  1'b0, 8'h00);
          default: step = mk(K_END,   1'b0, 8'h00);
        endcase
      end
      default: step = mk(K_END, 1'b0, 8'h00);
    endcase
  end
endmodule

// File: rtl/mpn_byte_ctr.sv
module mpn_byte_ctr #(
  parameter int PAGE_BYTES = 4314
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  output logic last
);
  localparam int CW = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;

  logic [CW-1:0] cnt;

  assign last = (cnt == CW'(PAGE_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (inc)  cnt <= last ? '0 : cnt + 1'b1;
  end

  // R8: the page counter restarts exactly after the final byte of a plane
  assert_wrap_at_page_R8: assert property (@(posedge clk) disable iff (rst)
    (inc && last) |=> (cnt == '0));
endmodule

// File: rtl/mpn_busy_timer.sv
module mpn_busy_timer #(
  parameter int TO_W = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [TO_W-1:0] limit,
  output logic            expired
);
  logic [TO_W-1:0] cnt;

  assign expired = run && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run)    cnt <= '0;
    else if (cnt != '1) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mpn_seq.sv
module mpn_seq
  import mpn_pkg::*;
#(
  parameter int PAGE_BYTES = 4314,
  parameter int TO_W       = 20,
  parameter int WB_CYC     = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      op_a,
  input  logic [1:0]      op_b,
  input  logic [39:0]     addr_a,
  input  logic [39:0]     addr_b,
  input  logic [TO_W-1:0] busy_limit,
  input  logic [7:0]      wr_data,
  output logic            wr_req,
  output logic [7:0]      rd_data,
  output logic            rd_valid,
  output logic            rd_plane,
  output logic            busy,
  output logic            done,
  output logic            err_mix,
  output logic            err_timeout,
  output logic            status_fail,
  output logic            fl_cle,
  output logic            fl_ale,
  output logic            fl_we_n,
  output logic            fl_re_n,
  output logic [7:0]      fl_dq_out,
  output logic            fl_dq_oe,
  input  logic [7:0]      fl_dq_in,
  input  logic            fl_rb_n
);
  localparam int WBW = $clog2(WB_CYC + 1);

  logic          run, ph, rb_m, rb_s;
  op_e           op_q;
  logic [IW-1:0] idx;
  logic [2:0]    acnt, acnt_base;
  logic [WBW-1:0] wbc;
  logic [39:0]   a_q, b_q, cur_addr;
  step_t         st;

  logic       cle_nx, ale_nx, we_nx, re_nx, oe_nx, step_end, tmr_run, tmr_exp;
  logic       ctr_inc, blast, wb_done;
  logic [7:0] dq_nx, abyte;

  mpn_step_rom u_rom (.op(op_q), .idx(idx), .step(st));

  mpn_byte_ctr #(.PAGE_BYTES(PAGE_BYTES)) u_ctr (
    .clk(clk), .rst(rst), .inc(ctr_inc), .last(blast));

  mpn_busy_timer #(.TO_W(TO_W)) u_tmr (
    .clk(clk), .rst(rst), .run(tmr_run), .limit(busy_limit), .expired(tmr_exp));

  assign busy      = run;
  assign acnt_base = (op_q == OP_ERASE) ? 3'(ROW_START) : 3'd0;
  assign cur_addr  = st.plane ? b_q : a_q;
  assign abyte     = cur_addr[{acnt, 3'b000} +: 8];
  assign wb_done   = (wbc == WBW'(WB_CYC));
  assign ctr_inc   = run && ph && (st.kind == K_WDATA || st.kind == K_RDATA);

  always_comb begin
    cle_nx = 1'b0; ale_nx = 1'b0; we_nx = 1'b1; re_nx = 1'b1; oe_nx = 1'b0;
    dq_nx = fl_dq_out; step_end = 1'b0; tmr_run = 1'b0;
    if (run) begin
      unique case (st.kind)
        K_CMD: begin
          cle_nx = 1'b1; oe_nx = 1'b1; dq_nx = st.val; we_nx = ph; step_end = ph;
        end
        K_ADDR: begin
          ale_nx = 1'b1; oe_nx = 1'b1; dq_nx = abyte; we_nx = ph;
          step_end = ph && (acnt == 3'(ADDR_CYCLES - 1));
        end
        K_WDATA: begin
          oe_nx = 1'b1; dq_nx = ph ? fl_dq_out : wr_data; we_nx = ph;
          step_end = ph && blast;
        end
        K_RDATA: begin
          re_nx = ph; step_end = ph && blast;
        end
        K_STAT: begin
          re_nx = ph; step_end = ph;
        end
        K_WAIT: begin
          tmr_run = 1'b1; step_end = wb_done && rb_s;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0; ph <= 1'b0; op_q <= OP_READ; idx <= '0; acnt <= '0; wbc <= '0;
      a_q <= '0; b_q <= '0; rb_m <= 1'b1; rb_s <= 1'b1;
      fl_cle <= 1'b0; fl_ale <= 1'b0; fl_we_n <= 1'b1; fl_re_n <= 1'b1;
      fl_dq_out <= '0; fl_dq_oe <= 1'b0;
      wr_req <= 1'b0; rd_data <= '0; rd_valid <= 1'b0; rd_plane <= 1'b0;
      done <= 1'b0; err_mix <= 1'b0; err_timeout <= 1'b0; status_fail <= 1'b0;
    end else begin
      fl_cle <= cle_nx; fl_ale <= ale_nx; fl_we_n <= we_nx; fl_re_n <= re_nx;
      fl_dq_out <= dq_nx; fl_dq_oe <= oe_nx;
      rb_m <= fl_rb_n; rb_s <= rb_m;
      done <= 1'b0; err_mix <= 1'b0; wr_req <= 1'b0; rd_valid <= 1'b0;
      if (!run) begin
        if (start) begin
          if (op_a != op_b || op_a == OP_BAD) begin
            err_mix <= 1'b1;
          end else begin
            run  <= 1'b1; op_q <= op_e'(op_a); a_q <= addr_a; b_q <= addr_b;
            idx  <= '0; ph <= 1'b0; wbc <= '0;
            acnt <= (op_a == OP_ERASE) ? 3'(ROW_START) : 3'd0;
            err_timeout <= 1'b0; status_fail <= 1'b0;
          end
        end
      end else begin
        if (st.kind inside {K_CMD, K_ADDR, K_WDATA, K_RDATA, K_STAT}) ph <= ~ph;
        if (st.kind == K_ADDR && ph) acnt <= step_end ? acnt_base : acnt + 3'd1;
        if (st.kind == K_WDATA && !ph) wr_req <= 1'b1;
        if (st.kind == K_RDATA && ph) begin
          rd_valid <= 1'b1; rd_data <= fl_dq_in; rd_plane <= st.plane;
        end
        if (st.kind == K_STAT && ph) status_fail <= fl_dq_in[0];
        if (st.kind == K_WAIT && !wb_done) wbc <= wbc + 1'b1;
        if (step_end) begin
          idx <= idx + 1'b1; ph <= 1'b0; wbc <= '0;
        end
        if (st.kind == K_WAIT && tmr_exp && !step_end) begin
          run <= 1'b0; done <= 1'b1; err_timeout <= 1'b1; wbc <= '0;
        end
        if (st.kind == K_END) begin
          run <= 1'b0; done <= 1'b1;
        end
      end
    end
  end

  // R1: a request with differing or invalid operations never starts
  assert_reject_mix_R1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (op_a != op_b || op_a == 2'd3)) |=> (err_mix && !busy));

  // R2: command and address latches are exclusive
  assert_latch_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(fl_cle && fl_ale));

  // R3: no write strobe while the die reports busy
  assert_no_strobe_busy_R3: assert property (@(posedge clk) disable iff (rst)
    !fl_rb_n |-> fl_we_n);

  // R5: program bytes are requested only by a program
  assert_wrreq_prog_R5: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> (op_q == OP_PROG));

  // R9: a timeout can only end a ready/busy wait
  assert_timeout_in_wait_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(err_timeout) |-> $past(run && st.kind == K_WAIT));

  // R10: completion is reported only with busy low
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/mpn_seq_tb_top.sv
module mpn_seq_tb_top;
  localparam int PAGE = 4314;
  localparam int TO_W = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic            start = 1'b0;
  logic [1:0]      op_a = 2'd0, op_b = 2'd0;
  logic [39:0]     addr_a = '0, addr_b = '0;
  logic [TO_W-1:0] busy_limit = TO_W'(300);
  logic [7:0]      wr_data, rd_data, fl_dq_out, fl_dq_in;
  logic            wr_req, rd_valid, rd_plane, busy, done, err_mix, err_timeout, status_fail;
  logic            fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe, fl_rb_n;

  mpn_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .addr_a(addr_a), .addr_b(addr_b), .busy_limit(busy_limit),
    .wr_data(wr_data), .wr_req(wr_req), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_plane(rd_plane), .busy(busy), .done(done), .err_mix(err_mix),
    .err_timeout(err_timeout), .status_fail(status_fail),
    .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we_n(fl_we_n), .fl_re_n(fl_re_n),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_rb_n(fl_rb_n));

  int nchk = 0, nfail = 0;
  int busy_len = 40;
  logic [7:0] stat_val = 8'h00;

  // flash model state (owned by the monitor process)
  logic rb_n = 1'b1, stat_mode = 1'b0, rd_pl = 1'b0, we_d = 1'b1, re_d = 1'b1, conf_pend = 1'b0;
  int rd_idx = 0, busy_left = 0, ev_cnt = 0, done_cnt = 0, mix_cnt = 0, wcnt = 0, cyc = 0, conf_cyc = 0;

  logic [9:0] exp_ev[$];
  string      exp_tag[$];
  logic [8:0] exp_rd[$];

  function automatic logic [7:0] rpat(logic p, int i);
    return 8'((i * 7) + (p ? 91 : 0) + (i >> 8));
  endfunction
  function automatic logic [7:0] wpat(int n);
    return 8'(n * 13 + 5);
  endfunction

  assign fl_dq_in = stat_mode ? stat_val : rpat(rd_pl, rd_idx);
  assign fl_rb_n  = rb_n;
  assign wr_data  = wpat(wcnt);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: flash model plus scoreboard comparison
  always @(negedge clk) begin
    logic [9:0] ev, e;
    string t;
    logic [8:0] r;
    if (!rst) begin
      cyc++;
      if (busy_left > 0) begin
        busy_left--;
        if (busy_left == 0) rb_n = 1'b1;
      end
      if (!we_d && fl_we_n) begin
        ev = {(fl_cle ? 2'd1 : (fl_ale ? 2'd2 : 2'd3)), fl_dq_out};
        ev_cnt++;
        chk(rb_n, "R3 strobe during busy", 0, 1);
        if (conf_pend) begin
          conf_pend = 1'b0;
          chk((cyc - conf_cyc) > busy_len, "R3 wait after confirm", cyc - conf_cyc, busy_len);
        end
        if (exp_ev.size() == 0) chk(1'b0, "R2 unexpected bus cycle", ev, 0);
        else begin
          e = exp_ev.pop_front(); t = exp_tag.pop_front();
          chk(ev == e, t, ev, e);
        end
        if (fl_cle) begin
          case (fl_dq_out)
            8'h30: begin busy_left = busy_len; rb_n = 1'b0; rd_pl = 1'b0; rd_idx = 0;
                         stat_mode = 1'b0; conf_pend = 1'b1; conf_cyc = cyc; end
            8'h10, 8'hD0: begin busy_left = busy_len; rb_n = 1'b0;
                               conf_pend = 1'b1; conf_cyc = cyc; end
            8'h70: stat_mode = 1'b1;
            8'h00, 8'h06: stat_mode = 1'b0;
            8'hE0: begin rd_pl = 1'b1; rd_idx = 0; end
            default: ;
          endcase
        end
      end
      if (!re_d && fl_re_n && !stat_mode) rd_idx++;
      if (rd_valid) begin
        if (exp_rd.size() == 0) chk(1'b0, "R4 unexpected read byte", {rd_plane, rd_data}, 0);
        else begin
          r = exp_rd.pop_front();
          chk({rd_plane, rd_data} == r, "R4 R8 read byte and plane", {rd_plane, rd_data}, r);
        end
      end
      if (wr_req) wcnt++;
      if (done) done_cnt++;
      if (err_mix) mix_cnt++;
      we_d = fl_we_n;
      re_d = fl_re_n;
    end
  end

  // driver tasks
  task automatic push(input logic [9:0] e, input string t);
    exp_ev.push_back(e);
    exp_tag.push_back(t);
  endtask
  task automatic push_cmd(input logic [7:0] c, input string t);
    push({2'd1, c}, t);
  endtask
  task automatic push_addr(input logic [39:0] a, input bit row_only, input string t);
    for (int k = (row_only ? 2 : 0); k < 5; k++) push({2'd2, a[k*8 +: 8]}, t);
  endtask
  task automatic push_wr(input int base, input int p);
    for (int i = 0; i < PAGE; i++) push({2'd3, wpat(base + p * PAGE + i)}, "R5 R8 write byte");
  endtask
  task automatic push_rd(input logic p);
    for (int i = 0; i < PAGE; i++) exp_rd.push_back({p, rpat(p, i)});
  endtask

  task automatic run_op(input logic [1:0] op, input logic [39:0] a, input logic [39:0] b);
    int d0;
    d0 = done_cnt;
    @(negedge clk);
    op_a = op; op_b = op; addr_a = a; addr_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", busy, 1);
    while (done_cnt == d0) @(negedge clk);
    chk(busy == 1'b0, "R10 busy low at done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R10 done is one pulse", done, 0);
  endtask

  task automatic do_read(input logic [39:0] a, input logic [39:0] b);
    push_cmd(8'h00, "R2 read open A"); push_addr(a, 1'b0, "R2 address A");
    push_cmd(8'h00, "R2 read open B"); push_addr(b, 1'b0, "R2 address B");
    push_cmd(8'h30, "R2 single read confirm");
    push_rd(1'b0);
    push_cmd(8'h06, "R4 reselect"); push_addr(b, 1'b0, "R4 reselect address B");
    push_cmd(8'hE0, "R4 reselect confirm");
    push_rd(1'b1);
    run_op(2'd0, a, b);
    chk(exp_ev.size() == 0, "R8 read bus cycles consumed", exp_ev.size(), 0);
    chk(exp_rd.size() == 0, "R8 read bytes consumed", exp_rd.size(), 0);
    chk(status_fail == 1'b0, "R7 no status on read", status_fail, 0);
    chk(err_timeout == 1'b0, "R9 no timeout on read", err_timeout, 0);
  endtask

  initial begin
    int ev0, m0, base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R10 reset busy", busy, 0);
    chk(fl_we_n && fl_re_n, "R10 reset enables high", {fl_we_n, fl_re_n}, 2'b11);
    chk(!fl_cle && !fl_ale && !fl_dq_oe, "R10 reset latches idle", {fl_cle, fl_ale, fl_dq_oe}, 0);

    // R1: mixed and invalid requests
    ev0 = ev_cnt; m0 = mix_cnt;
    op_a = 2'd0; op_b = 2'd2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    chk(mix_cnt == m0 + 1, "R1 mixed request refused", mix_cnt - m0, 1);
    chk(busy == 1'b0, "R1 mixed request not started", busy, 0);
    op_a = 2'd3; op_b = 2'd3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    chk(mix_cnt == m0 + 2, "R1 invalid code refused", mix_cnt - m0, 2);
    chk(ev_cnt == ev0, "R1 no bus cycles on refusal", ev_cnt - ev0, 0);

    // read, two address patterns
    do_read(40'h03_2211_0A10, 40'h03_2212_0B20);

    // program
    base = wcnt; stat_val = 8'h00;
    push_cmd(8'h80, "R5 program open A"); push_addr(40'h01_0040_0000, 1'b0, "R5 address A");
    push_wr(base, 0);
    push_cmd(8'h11, "R5 hold confirm");
    push_cmd(8'h80, "R5 program open B"); push_addr(40'h01_0041_0000, 1'b0, "R5 address B");
    push_wr(base, 1);
    push_cmd(8'h10, "R5 start confirm");
    push_cmd(8'h70, "R7 status after program");
    run_op(2'd1, 40'h01_0040_0000, 40'h01_0041_0000);
    chk(wcnt - base == 2 * PAGE, "R8 program bytes requested", wcnt - base, 2 * PAGE);
    chk(exp_ev.size() == 0, "R5 program cycles consumed", exp_ev.size(), 0);
    chk(status_fail == 1'b0, "R7 program pass", status_fail, 0);

    // erase with failing status
    stat_val = 8'h01;
    push_cmd(8'h60, "R6 erase open A"); push_addr(40'h07_8000_0000, 1'b1, "R6 row A");
    push_cmd(8'h60, "R6 erase open B"); push_addr(40'h07_8040_0000, 1'b1, "R6 row B");
    push_cmd(8'hD0, "R6 single erase confirm");
    push_cmd(8'h70, "R7 status after erase");
    run_op(2'd2, 40'h07_8000_0000, 40'h07_8040_0000);
    chk(exp_ev.size() == 0, "R6 erase cycles consumed", exp_ev.size(), 0);
    chk(status_fail == 1'b1, "R7 erase fail bit", status_fail, 1);

    // second read, longer busy
    busy_len = 100;
    do_read(40'h0F_FFFF_10DA, 40'h00_0001_0000);

    // timeout
    busy_len = 3000; busy_limit = TO_W'(300); stat_val = 8'h00;
    push_cmd(8'h60, "R9 erase open A"); push_addr(40'h02_0100_0000, 1'b1, "R9 row A");
    push_cmd(8'h60, "R9 erase open B"); push_addr(40'h02_0140_0000, 1'b1, "R9 row B");
    push_cmd(8'hD0, "R9 erase confirm");
    run_op(2'd2, 40'h02_0100_0000, 40'h02_0140_0000);
    chk(err_timeout == 1'b1, "R9 timeout flagged", err_timeout, 1);
    ev0 = ev_cnt;
    repeat (50) @(negedge clk);
    chk(ev_cnt == ev0, "R9 bus idle after timeout", ev_cnt - ev0, 0);
    chk(fl_we_n && fl_re_n && !fl_cle && !fl_ale, "R9 strobes idle", {fl_we_n, fl_re_n, fl_cle, fl_ale}, 4'b1100);
    chk(exp_ev.size() == 0, "R9 no status after timeout", exp_ev.size(), 0);
    while (!rb_n) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule